// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the address stream for one DMA channel. A transfer is a block of frames, and every frame holds the same number of elements. At launch the block captures two start addresses, an element count per frame, a frame count per block, an element size and, for each side (source and destination), an addressing mode and two signed strides: one applied between elements and one applied at a frame boundary. It then offers one source/destination address pair per element on a valid/ready stream. Each accepted handshake retires one element.

A write strobe with a start value models the start bit of the channel's control register. Writing it set while the channel is idle launches a block. Writing it clear while the channel runs aborts the block. The start bit clears itself when the block ends. Four single-cycle event pulses report progress: half frame reached, frame done, last frame started and block done. Data movement, packing and bus protocol are left to the logic that consumes the stream.

The stream has these back-pressure rules. `out_valid` stays high from launch until the last element is accepted or the block is aborted. While `out_valid` is high and `out_ready` is low, both addresses hold. An element counts as accepted only on a rising edge where both are high and no abort write is present.

Top module: `dma2d_addr_seq`

## Requirements
- R1: A control write with `ctl_start`=1 while idle, with nonzero element and frame counts, makes `busy` and `out_valid` high in the next cycle. The outputs then show the start addresses, and all configuration inputs are captured on that edge.
- R2: Each accepted handshake retires exactly one element, and a block retires element count × frame count elements. While `out_valid` is high and `out_ready` is low (and no abort is written), `out_valid` stays high and both addresses hold.
- R3: The mode code selects how an address advances after each accepted element. 0 keeps it constant. 1 adds the element size in bytes. 2 adds size + element stride − 1. 3 adds size + element stride − 1 inside a frame and size + frame stride − 1 after a frame's last element. Strides are 16-bit two's complement values.
- R4: The element size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 also gives 4 bytes.
- R5: `ev_half_frame` pulses for one cycle after the floor(E/2)-th element of each frame is accepted. It never pulses when E = 1.
- R6: `ev_frame_done` pulses for one cycle after the last element of each frame is accepted.
- R7: `ev_last_frame` pulses once per block, in the first cycle in which the last frame is current. When F = 1 this is the cycle after launch.
- R8: In the cycle after the final element is accepted, `ev_block_done` is high for exactly one cycle, and `busy` and `out_valid` are low.
- R9: A start write with a zero element count or zero frame count issues no address. `ev_block_done` pulses in the next cycle and `busy` stays low.
- R10: A control write with `ctl_start`=0 while busy drops `busy` and `out_valid` in the next cycle, without `ev_block_done`.
- R11: A start write while busy has no effect. The transfer continues from the same address and the same element position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start bit value carried by the write |
| busy | output | 1 | Start bit read-back; high while a block runs |
| cfg_src_addr | input | AW (32) | Source start byte address |
| cfg_dst_addr | input | AW (32) | Destination start byte address |
| cfg_elem_cnt | input | EW (24) | Elements per frame |
| cfg_frame_cnt | input | FW (16) | Frames per block |
| cfg_elem_size | input | 2 | Element size code |
| cfg_src_mode | input | 2 | Source address mode code |
| cfg_dst_mode | input | 2 | Destination address mode code |
| cfg_src_estride | input | IW (16) | Source signed element stride |
| cfg_src_fstride | input | IW (16) | Source signed frame stride |
| cfg_dst_estride | input | IW (16) | Destination signed element stride |
| cfg_dst_fstride | input | IW (16) | Destination signed frame stride |
| out_valid | output | 1 | An address pair is offered |
| out_ready | input | 1 | Consumer accepts the offered pair |
| out_src_addr | output | AW (32) | Current source byte address |
| out_dst_addr | output | AW (32) | Current destination byte address |
| ev_half_frame | output | 1 | Half-frame pulse |
| ev_frame_done | output | 1 | Frame-complete pulse |
| ev_last_frame | output | 1 | Last-frame-started pulse |
| ev_block_done | output | 1 | Block-complete pulse |

## Verification
Every cycle, the assertions check these properties:
- the stream holds under back-pressure;
- a constant-mode address never moves, and an incrementing one moves by exactly the element size;
- the counters stay inside the captured frame and element bounds;
- the last-frame pulse appears only at the first element of the final frame;
- a half-frame pulse never coincides with a frame-done pulse;
- abort, restart and zero-count writes have the required next-cycle effect.

Only the bench's scenarios can show the rest. That covers the exact address sequences of the stride modes with negative strides and at frame boundaries, the number and position of every event per block, and the total element count.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  localparam int NSIDE = 2;

  typedef enum logic [1:0] {
    AM_CONST  = 2'd0,
    AM_INCR   = 2'd1,
    AM_SINGLE = 2'd2,
    AM_DOUBLE = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ES_BYTE = 2'd0,
    ES_HALF = 2'd1,
    ES_WORD = 2'd2,
    ES_RSVD = 2'd3
  } esize_e;

  function automatic logic [2:0] esize_bytes(esize_e s);
    case (s)
      ES_BYTE: return 3'd1;
      ES_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_start,
  input  logic cnt_zero,
  input  logic fin,
  output logic run,
  output logic launch,
  output logic abort,
  output logic block_done
);

  logic zero_req;

  assign launch   = ctl_we && ctl_start && !run && !cnt_zero;
  assign zero_req = ctl_we && ctl_start && !run && cnt_zero;
  assign abort    = ctl_we && !ctl_start && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      block_done <= 1'b0;
    end else begin
      block_done <= zero_req || fin;
      if (launch)
        run <= 1'b1;
      else if (abort || fin)
        run <= 1'b0;
    end
  end

  // R8: the completion pulse only ever appears with the start bit cleared
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> !run);

  // R10: an abort stops the channel without a completion pulse
  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!run && !block_done));

  // R9: empty block completes at once without running
  assert_zero_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (block_done && !run));

  // R11: restart while running keeps the channel running
  assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_start && run && !fin) |=> run);

endmodule

// File: rtl/dma2d_count.sv
module dma2d_count #(
  parameter int EW = 24,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          launch,
  input  logic          step,
  input  logic [EW-1:0] elem_cnt,
  input  logic [FW-1:0] frame_cnt,
  output logic          last_elem,
  output logic          last_frame,
  output logic          ev_half,
  output logic          ev_frame,
  output logic          ev_lastfrm
);

  logic [EW-1:0] e_idx, e_tot, half_pt, e_nxt;
  logic [FW-1:0] f_idx, f_tot;
  logic          next_is_last;

  assign half_pt    = e_tot >> 1;
  assign e_nxt      = e_idx + EW'(1);
  assign last_elem  = (e_idx == e_tot - EW'(1));
  assign last_frame = (f_idx == f_tot - FW'(1));
  assign next_is_last = ({1'b0, f_idx} + (FW+1)'(2)) == {1'b0, f_tot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_idx      <= '0;
      e_tot      <= '0;
      f_idx      <= '0;
      f_tot      <= '0;
      ev_half    <= 1'b0;
      ev_frame   <= 1'b0;
      ev_lastfrm <= 1'b0;
    end else begin
      ev_half    <= 1'b0;
      ev_frame   <= 1'b0;
      ev_lastfrm <= 1'b0;
      if (launch) begin
        e_idx      <= '0;
        f_idx      <= '0;
        e_tot      <= elem_cnt;
        f_tot      <= frame_cnt;
        ev_lastfrm <= (frame_cnt == FW'(1));
      end else if (step) begin
        ev_half <= (e_nxt == half_pt);
        if (last_elem) begin
          e_idx      <= '0;
          f_idx      <= f_idx + FW'(1);
          ev_frame   <= 1'b1;
          ev_lastfrm <= !last_frame && next_is_last;
        end else begin
          e_idx <= e_nxt;
        end
      end
    end
  end

  // R5: half point lies strictly inside a frame, never on its end
  assert_half_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_half && ev_frame));

  // R2: positions stay within the captured bounds while running
  assert_elem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((e_idx < e_tot) && (f_idx < f_tot)));

  // R7: last-frame pulse coincides with the first element of the final frame
  assert_lastfrm_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lastfrm |-> (run && last_frame && (e_idx == '0)));

endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  amode_e        mode,
  input  esize_e        esize,
  input  logic [IW-1:0] estride,
  input  logic [IW-1:0] fstride,
  input  logic          step,
  input  logic          frame_end,
  output logic [AW-1:0] addr
);

  amode_e        mode_q;
  logic [2:0]    esz_q;
  logic [IW-1:0] es_q, fs_q;
  logic [AW-1:0] ebytes, e_ext, f_ext, e_delta, f_delta, delta;

  assign ebytes  = AW'(esz_q);
  assign e_ext   = {{(AW-IW){es_q[IW-1]}}, es_q};
  assign f_ext   = {{(AW-IW){fs_q[IW-1]}}, fs_q};
  assign e_delta = ebytes + e_ext - AW'(1);
  assign f_delta = ebytes + f_ext - AW'(1);

  always_comb begin
    case (mode_q)
      AM_CONST:  delta = '0;
      AM_INCR:   delta = ebytes;
      AM_SINGLE: delta = e_delta;
      default:   delta = frame_end ? f_delta : e_delta;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      mode_q <= AM_CONST;
      esz_q  <= 3'd1;
      es_q   <= '0;
      fs_q   <= '0;
    end else if (load) begin
      addr   <= start_addr;
      mode_q <= mode;
      esz_q  <= esize_bytes(esize);
      es_q   <= estride;
      fs_q   <= fstride;
    end else if (step) begin
      addr <= addr + delta;
    end
  end

  // R3: constant mode never moves the address
  assert_const_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode_q == AM_CONST) |=> $stable(addr));

  // R3: post-increment advances by exactly one element
  assert_incr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode_q == AM_INCR) |=> (addr == $past(addr) + AW'($past(esz_q))));

  // R4: captured element size is one of the legal byte widths
  assert_esz_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(esz_q) == 1 && esz_q != 3'd0);

endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int EW = 24,
  parameter int FW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_start,
  output logic          busy,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [EW-1:0] cfg_elem_cnt,
  input  logic [FW-1:0] cfg_frame_cnt,
  input  logic [1:0]    cfg_elem_size,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic [IW-1:0] cfg_src_estride,
  input  logic [IW-1:0] cfg_src_fstride,
  input  logic [IW-1:0] cfg_dst_estride,
  input  logic [IW-1:0] cfg_dst_fstride,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_src_addr,
  output logic [AW-1:0] out_dst_addr,
  output logic          ev_half_frame,
  output logic          ev_frame_done,
  output logic          ev_last_frame,
  output logic          ev_block_done
);

  logic run, launch, abort, step, fin, cnt_zero;
  logic last_elem, last_frame;

  logic [AW-1:0] side_start [NSIDE];
  logic [AW-1:0] side_addr  [NSIDE];
  logic [1:0]    side_mode  [NSIDE];
  logic [IW-1:0] side_es    [NSIDE];
  logic [IW-1:0] side_fs    [NSIDE];

  assign side_start[0] = cfg_src_addr;
  assign side_start[1] = cfg_dst_addr;
  assign side_mode[0]  = cfg_src_mode;
  assign side_mode[1]  = cfg_dst_mode;
  assign side_es[0]    = cfg_src_estride;
  assign side_es[1]    = cfg_dst_estride;
  assign side_fs[0]    = cfg_src_fstride;
  assign side_fs[1]    = cfg_dst_fstride;

  assign cnt_zero  = (cfg_elem_cnt == '0) || (cfg_frame_cnt == '0);
  assign step      = run && out_ready && !abort;
  assign fin       = step && last_elem && last_frame;
  assign out_valid = run;
  assign busy      = run;

  dma2d_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_start  (ctl_start),
    .cnt_zero   (cnt_zero),
    .fin        (fin),
    .run        (run),
    .launch     (launch),
    .abort      (abort),
    .block_done (ev_block_done)
  );

  dma2d_count #(.EW(EW), .FW(FW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .launch     (launch),
    .step       (step),
    .elem_cnt   (cfg_elem_cnt),
    .frame_cnt  (cfg_frame_cnt),
    .last_elem  (last_elem),
    .last_frame (last_frame),
    .ev_half    (ev_half_frame),
    .ev_frame   (ev_frame_done),
    .ev_lastfrm (ev_last_frame)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma2d_addr_step #(.AW(AW), .IW(IW)) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (launch),
      .start_addr (side_start[s]),
      .mode       (amode_e'(side_mode[s])),
      .esize      (esize_e'(cfg_elem_size)),
      .estride    (side_es[s]),
      .fstride    (side_fs[s]),
      .step       (step),
      .frame_end  (last_elem),
      .addr       (side_addr[s])
    );
  end

  assign out_src_addr = side_addr[0];
  assign out_dst_addr = side_addr[1];

  // R2: a stalled offer is held unchanged
  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(ctl_we && !ctl_start)) |=>
      (out_valid && $stable(out_src_addr) && $stable(out_dst_addr)));

  // R11: a start write during a stalled transfer changes nothing
  assert_restart_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_start && out_valid && !out_ready) |=>
      (busy && $stable(out_src_addr) && $stable(out_dst_addr)));

  // R8: completion leaves no offer on the stream
  assert_done_novalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_block_done |-> !out_valid);

  // R1: a launch from idle offers the programmed start addresses
  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (out_valid && out_src_addr == $past(cfg_src_addr)
                && out_dst_addr == $past(cfg_dst_addr)));

endmodule

// File: tb/test_dma2d_addr_seq.sv
`timescale 1ns/1ps
module test_dma2d_addr_seq;

  typedef struct packed {
    logic [7:0]  e;
    logic [7:0]  f;
    logic [1:0]  sz;
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [15:0] sei;
    logic [15:0] sfi;
    logic [15:0] dei;
    logic [15:0] dfi;
    logic [31:0] sa;
    logic [31:0] da;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 8'd1, 2'd2, 2'd1, 2'd1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'h0000_1000, 32'h0000_2000},
    '{8'd3, 8'd2, 2'd0, 2'd0, 2'd1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'h0000_0040, 32'h0000_0800},
    '{8'd5, 8'd3, 2'd1, 2'd2, 2'd3, 16'h0003, 16'h0000, 16'h0001, 16'hFFF9, 32'h0001_0000, 32'h0002_0100},
    '{8'd1, 8'd4, 2'd3, 2'd3, 2'd2, 16'h0005, 16'hFFEC, 16'hFFFD, 16'h0000, 32'h0000_0400, 32'h0000_0010},
    '{8'd2, 8'd2, 2'd2, 2'd3, 2'd3, 16'h0009, 16'h0064, 16'h0001, 16'h0001, 32'h8000_0000, 32'h0000_0000},
    '{8'd6, 8'd1, 2'd0, 2'd2, 2'd2, 16'hFFFF, 16'h0000, 16'h0002, 16'h0000, 32'h0000_0005, 32'h0000_0100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, ctl_start = 1'b0;
  logic        busy;
  logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [23:0] cfg_elem_cnt = '0;
  logic [15:0] cfg_frame_cnt = '0;
  logic [1:0]  cfg_elem_size = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
  logic [15:0] cfg_src_estride = '0, cfg_src_fstride = '0;
  logic [15:0] cfg_dst_estride = '0, cfg_dst_fstride = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_src_addr, out_dst_addr;
  logic        ev_half_frame, ev_frame_done, ev_last_frame, ev_block_done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dma2d_addr_seq i_dma2d_addr_seq (
    .clk, .rst_n, .ctl_we, .ctl_start, .busy,
    .cfg_src_addr, .cfg_dst_addr, .cfg_elem_cnt, .cfg_frame_cnt,
    .cfg_elem_size, .cfg_src_mode, .cfg_dst_mode,
    .cfg_src_estride, .cfg_src_fstride, .cfg_dst_estride, .cfg_dst_fstride,
    .out_valid, .out_ready, .out_src_addr, .out_dst_addr,
    .ev_half_frame, .ev_frame_done, .ev_last_frame, .ev_block_done
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] a, logic [1:0] m, logic [1:0] sz,
                                      logic [15:0] ei, logic [15:0] fi, bit fend);
    int b, d;
    b = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    case (m)
      2'd0: d = 0;
      2'd1: d = b;
      2'd2: d = b + int'($signed(ei)) - 1;
      default: d = fend ? (b + int'($signed(fi)) - 1) : (b + int'($signed(ei)) - 1);
    endcase
    return a + 32'(d);
  endfunction

  task automatic load_cfg(input vec_t v);
    cfg_src_addr    = v.sa;
    cfg_dst_addr    = v.da;
    cfg_elem_cnt    = 24'(v.e);
    cfg_frame_cnt   = 16'(v.f);
    cfg_elem_size   = v.sz;
    cfg_src_mode    = v.sm;
    cfg_dst_mode    = v.dm;
    cfg_src_estride = v.sei;
    cfg_src_fstride = v.sfi;
    cfg_dst_estride = v.dei;
    cfg_dst_fstride = v.dfi;
  endtask

  task automatic ctl_write(input logic st);
    ctl_we = 1'b1;
    ctl_start = st;
    @(negedge clk);
    ctl_we = 1'b0;
    ctl_start = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int phase);
    logic [31:0] sa, da;
    int me, mf, nel, nh, nf, nl, cyc;
    bit done, rdy, fend;
    int ee, ff;
    ee = int'(v.e); ff = int'(v.f);
    sa = v.sa; da = v.da;
    me = 0; mf = 0; nel = 0; nh = 0; nf = 0; nl = 0; cyc = 0; done = 0;
    @(negedge clk);
    load_cfg(v);
    out_ready = 1'b0;
    ctl_write(1'b1);
    chk(out_valid && busy, "R1 launch valid", {30'd0, busy, out_valid}, 32'd3);
    chk(out_src_addr == v.sa && out_dst_addr == v.da, "R1 start address", out_src_addr, v.sa);
    while (!done && cyc < 2000) begin
      if (ev_half_frame) begin
        nh++;
        chk(me == ee / 2, "R5 half position", 32'(me), 32'(ee / 2));
      end
      if (ev_frame_done) begin
        nf++;
        chk(me == 0 && mf > 0, "R6 frame position", 32'(me), 32'd0);
      end
      if (ev_last_frame) begin
        nl++;
        chk(mf == ff - 1 && me == 0, "R7 last frame position", 32'(mf), 32'(ff - 1));
      end
      rdy = 1'b0;
      if (ev_block_done) begin
        done = 1;
        chk(!busy && !out_valid, "R8 idle at done", {30'd0, busy, out_valid}, 32'd0);
      end else if (out_valid) begin
        rdy = ((cyc + phase) % 3) != 2;
        if (rdy) begin
          chk(out_src_addr == sa, "R3 src address", out_src_addr, sa);
          chk(out_dst_addr == da, "R3 dst address", out_dst_addr, da);
          fend = (me == ee - 1);
          sa = nxt(sa, v.sm, v.sz, v.sei, v.sfi, fend);
          da = nxt(da, v.dm, v.sz, v.dei, v.dfi, fend);
          nel++;
          me++;
          if (fend) begin me = 0; mf++; end
        end
      end
      out_ready = rdy;
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(nel == ee * ff, "R2 element total", 32'(nel), 32'(ee * ff));
    chk(nf == ff, "R6 frame pulses", 32'(nf), 32'(ff));
    chk(nh == ((ee / 2 > 0) ? ff : 0), "R5 half pulses", 32'(nh), 32'((ee / 2 > 0) ? ff : 0));
    chk(nl == 1, "R7 last frame pulses", 32'(nl), 32'd1);
    chk(done, "R8 block done seen", 32'(done), 32'd1);
    if (!ev_block_done)
      chk(!busy && !ev_block_done, "R8 single pulse", {30'd0, busy, ev_block_done}, 32'd0);
    else
      chk(1'b0, "R8 single pulse", 32'd1, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid, "R8 reset idle", {30'd0, busy, out_valid}, 32'd0);
    chk(!ev_half_frame && !ev_frame_done && !ev_last_frame && !ev_block_done,
        "R5 reset events", {28'd0, ev_half_frame, ev_frame_done, ev_last_frame, ev_block_done}, 32'd0);

    // table walk: R1..R8 and R4 (code 3 in vector 3)
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9: zero element count, then zero frame count
    v = VECS[0];
    v.e = 8'd0;
    load_cfg(v);
    ctl_write(1'b1);
    chk(ev_block_done && !busy && !out_valid, "R9 zero elements", {29'd0, ev_block_done, busy, out_valid}, 32'd4);
    @(negedge clk);
    chk(!ev_block_done && !out_valid, "R9 zero single pulse", {30'd0, ev_block_done, out_valid}, 32'd0);
    v = VECS[1];
    v.f = 8'd0;
    load_cfg(v);
    ctl_write(1'b1);
    chk(ev_block_done && !busy && !out_valid, "R9 zero frames", {29'd0, ev_block_done, busy, out_valid}, 32'd4);
    @(negedge clk);

    // R10: abort mid block
    load_cfg(VECS[2]);
    ctl_write(1'b1);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    out_ready = 1'b0;
    ctl_write(1'b0);
    chk(!busy && !out_valid, "R10 abort idle", {30'd0, busy, out_valid}, 32'd0);
    held = 0;
    repeat (6) begin
      if (ev_block_done || out_valid) held++;
      @(negedge clk);
    end
    chk(held == 0, "R10 no completion after abort", 32'(held), 32'd0);

    // R11 and R2: restart ignored, stall holds
    load_cfg(VECS[0]);
    ctl_write(1'b1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    cfg_src_addr = 32'hDEAD_0000;
    ctl_write(1'b1);
    chk(busy && out_src_addr == 32'h0000_1004, "R11 restart ignored", out_src_addr, 32'h0000_1004);
    repeat (3) @(negedge clk);
    chk(out_valid && out_src_addr == 32'h0000_1004 && out_dst_addr == 32'h0000_2004,
        "R2 stall holds", out_dst_addr, 32'h0000_2004);
    out_ready = 1'b1;
    held = 0;
    while (!ev_block_done && held < 50) begin
      @(negedge clk);
      held++;
    end
    out_ready = 1'b0;
    chk(held == 3, "R11 remaining elements", 32'(held), 32'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule